// File: doc/BRIEF.md
# Horizontal Blanking Flag Generator

This block sits on a 10-bit digital video word stream that arrives one word per pixel clock. It searches the stream for timing reference sequences. Each sequence is an all-ones word, two all-zero words, and then an identifier word. From the identifier it tells an end-of-active-video marker from a start-of-active-video marker. From these markers it drives a registered horizontal blanking flag. The flag is low while a line carries active picture data.

A mode input picks one of two flag timings. In the default timing, the flag covers the whole blanking interval, including every word of both reference sequences. In the other timing, the flag follows only the H bit decoded from the identifier words. The block delays the data by three words, so the flag can rise on the first preamble word. The delayed data leaves the block together with the flag, so downstream logic sees the two aligned.

Top module: `hblank_flag`

## Requirements
- R1: After reset, `hflag` is 0 and `dout` is 0.
- R2: `dout` presents the word accepted three valid words earlier. The pipeline advances only on cycles where `din_vld` is 1.
- R3: A reference sequence is the consecutive valid words all-ones (0x3FF), 0x000, 0x000, followed by an identifier whose bit 9 is 1. Bit 6 of the identifier is the H bit: 1 marks end of active video (EAV) and 0 marks start of active video (SAV).
- R4: With mode 0 latched, `hflag` goes to 1 in the same cycle that `dout` shows the 0x3FF word of an EAV sequence.
- R5: With mode 0, `hflag` stays 1 through every word of the SAV sequence, including its identifier. It returns to 0 with the first word after that identifier.
- R6: With mode 1 latched, `hflag` stays 0 while `dout` shows the EAV preamble. It goes to 1 when `dout` shows the EAV identifier.
- R7: With mode 1, `hflag` stays 1 through the SAV preamble and identifier. It goes to 0 with the word after the SAV identifier.
- R8: After reset, `hflag` stays 0 until a reference sequence is detected. A SAV as the first sequence leaves it at 0.
- R9: A preamble that breaks before the identifier is ignored. The search restarts on the breaking word, so 3FF,000,3FF,000,000,ID is still detected.
- R10: The mode input is sampled only when a reference sequence is detected. A change made in the middle of a blanking interval takes effect at the next sequence.
- R11: A word with bit 9 equal to 0 that follows the preamble is not an identifier, and `hflag` is not changed by it.
- R12: `hflag` and `dout` do not change on cycles where `din_vld` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| din | input | DW (10) | Incoming video word |
| din_vld | input | 1 | Marks `din` as a valid word |
| blank_mode | input | 1 | 0: flag covers the full blanking interval; 1: flag follows the identifier H bit |
| hflag | output | 1 | Horizontal blanking flag, 1 during blanking |
| dout | output | DW (10) | Input words delayed by three valid words, aligned with `hflag` |

## Verification
The bench builds the block with its default parameters: a 10-bit word, with the H bit at position 6 and the identifier marker at position 9. These values let the bench use the real marker values 0x274 (EAV) and 0x200 (SAV). They also make it possible to build look-alike words, for example a 0x3FF inside a broken preamble or a post-preamble word with bit 9 clear. Each of these should be rejected. Bubbles in `din_vld` are placed between words to show that the delay is counted in words, not in clock cycles.

// File: rtl/hblank_flag.sv
module hblank_flag #(
  parameter int DW   = 10,
  parameter int HBIT = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] din,
  input  logic          din_vld,
  input  logic          blank_mode,
  output logic          hflag,
  output logic [DW-1:0] dout
);
  localparam logic [DW-1:0] ONES  = '1;
  localparam logic [DW-1:0] ZEROS = '0;
  localparam int IDBIT = DW - 1;

  logic [DW-1:0] p0, p1, p2;
  logic [2:0]    cnt;
  logic          h_eav, m_act, seen;
  logic          trs_hit;

  assign trs_hit = din_vld && din[IDBIT] && (p2 == ONES) && (p1 == ZEROS) && (p0 == ZEROS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      p0    <= '0;
      p1    <= '0;
      p2    <= '0;
      dout  <= '0;
      hflag <= 1'b0;
      cnt   <= 3'd0;
      h_eav <= 1'b0;
      m_act <= 1'b0;
      seen  <= 1'b0;
    end else if (din_vld) begin
      p0   <= din;
      p1   <= p0;
      p2   <= p1;
      dout <= p2;
      if (trs_hit) begin
        cnt   <= 3'd4;
        h_eav <= din[HBIT];
        m_act <= blank_mode;
        seen  <= 1'b1;
        if (!blank_mode && din[HBIT]) hflag <= 1'b1;
      end else begin
        if (cnt != 3'd0) cnt <= cnt - 3'd1;
        if (cnt == 3'd2 && m_act && h_eav) hflag <= 1'b1;
        if (cnt == 3'd1 && !h_eav) hflag <= 1'b0;
      end
    end
  end

  // R12
  a_r12_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !din_vld |=> ($stable(hflag) && $stable(dout)));

  // R4
  a_r4_rise_on_preamble: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(hflag) && !m_act) |-> (dout == ONES));

  // R6
  a_r6_rise_on_id: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(hflag) && m_act) |-> (dout[IDBIT] && dout[HBIT]));

  // R5 / R7
  a_r5_fall_after_sav: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hflag) |-> ($past(dout[IDBIT]) && !$past(dout[HBIT])));

  // R8
  a_r8_low_before_trs: assert property (@(posedge clk) disable iff (!rst_n)
    !seen |-> !hflag);
endmodule

// File: tb/hblank_flag_test.sv
module hblank_flag_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [9:0] din = '0;
  logic       din_vld = 1'b0;
  logic       blank_mode = 1'b0;
  logic       hflag;
  logic [9:0] dout;

  int total = 0;
  int bad = 0;

  logic [9:0] wv [0:63];
  logic       fv [0:63];
  logic       mv [0:63];
  int         n = 0;

  always #5 clk = ~clk;

  hblank_flag uut (
    .clk(clk), .rst_n(rst_n), .din(din), .din_vld(din_vld),
    .blank_mode(blank_mode), .hflag(hflag), .dout(dout)
  );

  task automatic check(input string req, input logic [9:0] ad, input logic [9:0] ed,
                       input logic af, input logic ef);
    total++;
    if (ad !== ed || af !== ef) begin
      bad++;
      $display("FAIL %s: dout=%h hflag=%b expected dout=%h hflag=%b", req, ad, af, ed, ef);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; din_vld = 1'b0; din = '0; blank_mode = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    n = 0;
  endtask

  task automatic add(input logic [9:0] w, input logic f, input logic m);
    wv[n] = w; fv[n] = f; mv[n] = m; n++;
  endtask

  task automatic active(input int k, input logic m);
    for (int i = 0; i < k; i++) add(10'h100 + 10'(i), 1'b0, m);
  endtask

  task automatic run_seq(input string req, input bit gaps);
    logic [9:0] hd;
    logic       hf;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      din = wv[i]; din_vld = 1'b1; blank_mode = mv[i];
      @(posedge clk);
      #1;
      if (i >= 3) check(req, dout, wv[i-3], hflag, fv[i-3]);
      if (gaps) begin
        @(negedge clk);
        hd = dout; hf = hflag;
        din = 10'h3FF; din_vld = 1'b0; blank_mode = ~mv[i];
        @(posedge clk);
        #1;
        check({req, " R12 idle"}, dout, hd, hflag, hf);
      end
    end
    @(negedge clk);
    din_vld = 1'b0;
  endtask

  task automatic line_m0(input logic m);
    add(10'h3FF, 1, m); add(10'h000, 1, m); add(10'h000, 1, m); add(10'h274, 1, m);
    add(10'h040, 1, m); add(10'h200, 1, m); add(10'h3FF, 1, m);
    add(10'h3FF, 1, m); add(10'h000, 1, m); add(10'h000, 1, m); add(10'h200, 1, m);
  endtask

  task automatic line_m1(input logic m);
    add(10'h3FF, 0, m); add(10'h000, 0, m); add(10'h000, 0, m); add(10'h274, 1, m);
    add(10'h040, 1, m); add(10'h200, 1, m);
    add(10'h3FF, 1, m); add(10'h000, 1, m); add(10'h000, 1, m); add(10'h200, 1, m);
  endtask

  task automatic t_reset();
    do_reset();
    #1;
    check("R1 reset", dout, 10'h000, hflag, 1'b0);
  endtask

  task automatic t_mode0();
    do_reset();
    active(4, 0); line_m0(0); active(4, 0); line_m0(0); active(3, 0);
    run_seq("R2 R3 R4 R5 mode0", 1'b0);
  endtask

  task automatic t_mode1();
    do_reset();
    active(4, 1); line_m1(1); active(4, 1);
    run_seq("R3 R6 R7 mode1", 1'b0);
  endtask

  task automatic t_sav_first();
    do_reset();
    active(3, 0);
    add(10'h3FF, 0, 0); add(10'h000, 0, 0); add(10'h000, 0, 0); add(10'h200, 0, 0);
    active(4, 0);
    run_seq("R8 sav first", 1'b0);
  endtask

  task automatic t_partial();
    do_reset();
    active(3, 0);
    add(10'h3FF, 0, 0); add(10'h000, 0, 0); add(10'h000, 0, 0); add(10'h074, 0, 0);
    active(2, 0);
    add(10'h3FF, 0, 0); add(10'h000, 0, 0); add(10'h3FF, 0, 0); add(10'h200, 0, 0);
    add(10'h3FF, 0, 0); add(10'h000, 0, 0);
    add(10'h3FF, 1, 0); add(10'h000, 1, 0); add(10'h000, 1, 0); add(10'h274, 1, 0);
    add(10'h080, 1, 0);
    run_seq("R9 R11 partial", 1'b0);
  endtask

  task automatic t_switch();
    do_reset();
    active(3, 0);
    add(10'h3FF, 1, 0); add(10'h000, 1, 0); add(10'h000, 1, 0); add(10'h274, 1, 0);
    add(10'h040, 1, 1); add(10'h040, 1, 1);
    add(10'h3FF, 1, 1); add(10'h000, 1, 1); add(10'h000, 1, 1); add(10'h200, 1, 1);
    active(3, 1);
    add(10'h3FF, 0, 1); add(10'h000, 0, 1); add(10'h000, 0, 1); add(10'h274, 1, 1);
    add(10'h040, 1, 0);
    add(10'h3FF, 1, 0); add(10'h000, 1, 0); add(10'h000, 1, 0); add(10'h200, 1, 0);
    active(4, 0);
    run_seq("R10 mode switch", 1'b0);
  endtask

  task automatic t_gaps();
    do_reset();
    active(3, 0); line_m0(0); active(4, 0);
    run_seq("R2 R12 gaps", 1'b1);
  endtask

  initial begin
    #100000;
    bad++; total++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_mode0();
    t_mode1();
    t_sav_first();
    t_partial();
    t_switch();
    t_gaps();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule